// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

The dispatcher sits between instruction fetch and the functional units of a wide-issue core. It receives fixed-width fetch packets of eight 32-bit instruction slots and splits each packet into variable-length execute packets. Bit 0 of every instruction is a chain flag. A set flag links that instruction to the next one, and a clear flag closes the group at that slot. Each clock issues at most one execute packet to eight lane outputs, and each lane has its own valid flag. Slot position stands in for the functional-unit index.

On the input side, a request/valid handshake brings in a new fetch packet, but only after every execute packet of the current one has been issued. On the output side, a stall input holds the issued packet and the scan position. Opcode decode and routing by unit type are left to later stages.

Top module: `ep_dispatch`

## Requirements
- R1: After reset is released, `fetch_req_o` is 1, `issue_valid_o` is all zero and `chain_err_o` is 0.
- R2: A fetch packet is taken at a rising edge where `fetch_req_o` and `fetch_valid_i` are both 1. From that edge `fetch_req_o` stays 0, and it returns to 1 in the same cycle that the last execute packet of the held packet appears on the outputs.
- R3: Slots are grouped from slot 0 upward. Bit 0 of an instruction equal to 1 joins the next slot to the same execute packet. Bit 0 equal to 0 ends the execute packet at that slot.
- R4: Execute packets are issued one per clock in ascending slot order. The first one appears one clock after the accepting edge when no stall is present.
- R5: Lane i of `issue_instr_o` (bits i*32+31 down to i*32) carries slot i's instruction unchanged when `issue_valid_o[i]` is 1. Otherwise that lane is zero.
- R6: If slot 7 has its chain bit set, its execute packet still ends at slot 7. `chain_err_o` is 1 for exactly that issue.
- R7: While `stall_i` is 1 at a rising edge, all issue outputs keep their values and no scan progress is made.
- R8: `fetch_valid_i` and `fetch_pkt_i` have no effect while `fetch_req_o` is 0.
- R9: With no fetch packet held and no stall, `issue_valid_o` becomes zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_o | output | 1 | Ready for a new fetch packet |
| fetch_valid_i | input | 1 | Fetch packet present on `fetch_pkt_i` |
| fetch_pkt_i | input | 256 | Eight instruction slots, slot i at bits i*32+31:i*32 |
| stall_i | input | 1 | Downstream hold |
| issue_valid_o | output | 8 | Per-lane valid of the issued execute packet |
| issue_instr_o | output | 256 | Per-lane instruction, zero in idle lanes |
| chain_err_o | output | 1 | Execute packet forced closed at the last slot |

## Verification
The bench builds the block with its default eight slots of 32 bits, so every execute-packet count from one to eight, every start position and the forced close at the final slot can all be reached. Directed packets cover all-break, all-chain and single-packet cases. Random chain patterns with random stalls and stray fetch-valid pulses follow. A queue-based model predicts the outputs and the fetch request every cycle.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int unsigned EP_SLOTS = 8;
  localparam int unsigned EP_IW    = 32;
endpackage

// File: rtl/ep_scan.sv
module ep_scan #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned PW    = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain_i,
  input  logic [PW-1:0]    ptr_i,
  output logic [PW-1:0]    end_o,
  output logic [SLOTS-1:0] mask_o,
  output logic             last_o,
  output logic             err_o
);
  logic found;
  always_comb begin
    end_o = PW'(SLOTS-1);
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!found && (PW+1)'(i) >= {1'b0, ptr_i} && !chain_i[i]) begin
        end_o = PW'(i);
        found = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_mask
    assign mask_o[g] = ((PW+1)'(g) >= {1'b0, ptr_i}) && ((PW+1)'(g) <= {1'b0, end_o});
  end

  assign last_o = (end_o == PW'(SLOTS-1));
  assign err_o  = last_o && chain_i[SLOTS-1];
endmodule

// File: rtl/ep_fetch_buf.sv
module ep_fetch_buf #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IW    = 32,
  parameter int unsigned PW    = $clog2(SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_valid_i,
  input  logic [SLOTS*IW-1:0] fetch_pkt_i,
  input  logic                advance_i,
  input  logic                last_i,
  input  logic [PW-1:0]       end_i,
  output logic                fetch_req_o,
  output logic                have_o,
  output logic [PW-1:0]       ptr_o,
  output logic [SLOTS*IW-1:0] pkt_o
);
  logic take;
  assign fetch_req_o = !have_o;
  assign take        = fetch_req_o && fetch_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_o <= 1'b0;
      ptr_o  <= '0;
      pkt_o  <= '0;
    end else if (take) begin
      have_o <= 1'b1;
      ptr_o  <= '0;
      pkt_o  <= fetch_pkt_i;
    end else if (advance_i) begin
      have_o <= !last_i;
      ptr_o  <= last_i ? '0 : end_i + PW'(1);
    end
  end

  assert_fetch_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !fetch_req_o);
  assert_scan_progress_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && have_o) |=> (!have_o || ptr_o > $past(ptr_o)));
endmodule

// File: rtl/ep_issue.sv
module ep_issue #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stall_i,
  input  logic                have_i,
  input  logic [SLOTS-1:0]    mask_i,
  input  logic                err_i,
  input  logic [SLOTS*IW-1:0] pkt_i,
  output logic [SLOTS-1:0]    valid_o,
  output logic [SLOTS*IW-1:0] instr_o,
  output logic                err_o
);
  logic [SLOTS*IW-1:0] lanes;
  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    assign lanes[g*IW +: IW] = mask_i[g] ? pkt_i[g*IW +: IW] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      instr_o <= '0;
      err_o   <= 1'b0;
    end else if (!stall_i) begin
      valid_o <= have_i ? mask_i : '0;
      instr_o <= have_i ? lanes : '0;
      err_o   <= have_i && err_i;
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(valid_o) && $stable(instr_o) && $stable(err_o)));
endmodule

// File: rtl/ep_dispatch.sv
module ep_dispatch
  import ep_pkg::*;
#(
  parameter int unsigned SLOTS = EP_SLOTS,
  parameter int unsigned IW    = EP_IW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                fetch_req_o,
  input  logic                fetch_valid_i,
  input  logic [SLOTS*IW-1:0] fetch_pkt_i,
  input  logic                stall_i,
  output logic [SLOTS-1:0]    issue_valid_o,
  output logic [SLOTS*IW-1:0] issue_instr_o,
  output logic                chain_err_o
);
  localparam int unsigned PW = $clog2(SLOTS);

  logic                have, last, err, advance;
  logic [PW-1:0]       ptr, end_idx;
  logic [SLOTS-1:0]    chain, mask;
  logic [SLOTS*IW-1:0] pkt;

  for (genvar g = 0; g < SLOTS; g++) begin : g_chain
    assign chain[g] = pkt[g*IW];
  end

  assign advance = have && !stall_i;

  ep_fetch_buf #(.SLOTS(SLOTS), .IW(IW), .PW(PW)) u_buf (
    .clk_i, .rst_ni, .fetch_valid_i, .fetch_pkt_i,
    .advance_i(advance), .last_i(last), .end_i(end_idx),
    .fetch_req_o, .have_o(have), .ptr_o(ptr), .pkt_o(pkt)
  );

  ep_scan #(.SLOTS(SLOTS), .PW(PW)) u_scan (
    .chain_i(chain), .ptr_i(ptr), .end_o(end_idx),
    .mask_o(mask), .last_o(last), .err_o(err)
  );

  ep_issue #(.SLOTS(SLOTS), .IW(IW)) u_issue (
    .clk_i, .rst_ni, .stall_i, .have_i(have), .mask_i(mask), .err_i(err),
    .pkt_i(pkt), .valid_o(issue_valid_o), .instr_o(issue_instr_o),
    .err_o(chain_err_o)
  );

  assert_err_at_tail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_err_o |-> issue_valid_o[SLOTS-1]);
  assert_idle_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!have && !stall_i) |=> (issue_valid_o == '0));
endmodule

// File: tb/ep_dispatch_test.sv
module ep_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam int IW = 32;

  typedef struct packed {
    logic [SLOTS-1:0]    m;
    logic [SLOTS*IW-1:0] d;
    logic                e;
  } ep_t;

  logic clk = 0, rst_ni = 0;
  logic fetch_valid = 0, stall = 0;
  logic [SLOTS*IW-1:0] fetch_pkt = '0;
  logic fetch_req, chain_err;
  logic [SLOTS-1:0] issue_valid;
  logic [SLOTS*IW-1:0] issue_instr;

  int tests = 0, fails = 0;
  ep_t q[$];
  ep_t exp_o = '0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_dispatch uut (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_req_o(fetch_req),
    .fetch_valid_i(fetch_valid), .fetch_pkt_i(fetch_pkt), .stall_i(stall),
    .issue_valid_o(issue_valid), .issue_instr_o(issue_instr),
    .chain_err_o(chain_err)
  );

  // Split a fetch packet into execute packets (R3, R6)
  task automatic split(input logic [SLOTS*IW-1:0] p);
    ep_t cur = '0;
    for (int i = 0; i < SLOTS; i++) begin
      cur.m[i] = 1'b1;
      cur.d[i*IW +: IW] = p[i*IW +: IW];
      if (!p[i*IW] || i == SLOTS-1) begin
        cur.e = (i == SLOTS-1) && p[i*IW];
        q.push_back(cur);
        cur = '0;
      end
    end
  endtask

  // Reference model: request high iff no execute packet is pending (R2)
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      exp_o = '0;
    end else begin
      logic req_now;
      req_now = (q.size() == 0);
      if (!stall) exp_o = (q.size() != 0) ? q.pop_front() : '0;  // R4, R9, R7
      if (req_now && fetch_valid) split(fetch_pkt);               // R8: ignored otherwise
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    chk(issue_valid == exp_o.m, "R3 valid", 256'(issue_valid), 256'(exp_o.m));
    chk(issue_instr == exp_o.d, "R5 instr", issue_instr, exp_o.d);
    chk(chain_err == exp_o.e, "R6 err", 256'(chain_err), 256'(exp_o.e));
    chk(fetch_req == (q.size() == 0), "R2 req", 256'(fetch_req), 256'(q.size() == 0));
  end

  function automatic logic [SLOTS*IW-1:0] mk(input logic [SLOTS-1:0] ch);
    logic [SLOTS*IW-1:0] p;
    for (int i = 0; i < SLOTS; i++) p[i*IW +: IW] = {$urandom} & ~32'h1 | 32'(ch[i]);
    return p;
  endfunction

  task automatic send(input logic [SLOTS-1:0] ch, input bit noise);
    @(negedge clk);
    while (!fetch_req) begin
      if (noise) begin  // R8: stray valid with junk while request is low
        fetch_valid = $urandom_range(0, 1);
        fetch_pkt = mk(SLOTS'($urandom));
      end
      @(negedge clk);
    end
    fetch_valid = 1;
    fetch_pkt = mk(ch);
    @(negedge clk);
    fetch_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state
    chk(fetch_req == 1, "R1 req", 256'(fetch_req), 256'(1));
    chk(issue_valid == 0 && chain_err == 0, "R1 outs", 256'(issue_valid), 256'(0));
    send(8'h00, 0);  // eight single-slot packets
    send(8'hFF, 0);  // one packet, forced close, R6
    send(8'h7F, 0);  // one full packet, no error
    send(8'h96, 0);
    send(8'h80, 0);  // R6 on a later packet
    repeat (12) @(negedge clk);  // R9 idle
    // R7: stalls mixed in
    fork
      begin
        for (int k = 0; k < 3000; k++) begin
          @(negedge clk);
          stall = ($urandom_range(0, 3) == 0);
        end
        stall = 0;
      end
      begin
        for (int k = 0; k < 300; k++) send(SLOTS'($urandom), k[0]);
      end
    join
    repeat (20) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule